// File: doc/BRIEF.md
# Test Access Port Controller with Instruction Decode

This block is the serial test port of a chip. One test clock drives all of its logic. A mode-select input steers a sixteen-state controller through its scan sequences. A serial input feeds both the instruction register and whichever data register the current instruction selects, and the serial output returns data from that same register.

Two data registers live inside the block: a single-bit bypass stage and a 32-bit identification word. The boundary register sits outside the block. It is driven through capture, shift and update strobes and returns its serial output on a dedicated input. Two further outputs tell the pad ring what to do: whether the boundary update stage drives the pins, and whether every output pad must be released to high impedance.

The instruction register is four bits wide and shifts least significant bit first. The encodings are:

| Instruction | Code | Scan path | `bnd_mode` | `pin_hiz` |
|---|---|---|---|---|
| EXTEST | 0000 | boundary | 1 | 0 |
| SAMPLE/PRELOAD | 0001 | boundary | 0 | 0 |
| IDCODE | 0010 | identification | 0 | 0 |
| CLAMP | 0011 | bypass | 1 | 0 |
| HIGHZ | 0100 | bypass | 0 | 1 |
| INTEST | 0101 | boundary | 1 | 0 |
| BYPASS | 1111 | bypass | 0 | 0 |
| any other code | — | bypass | 0 | 0 |

Top module: `tap_top`

## Requirements
- R1: While `tap_rst` is high, the controller is forced asynchronously into its reset state and the active instruction becomes IDCODE (0010). At release, `scan_out_en`, `bnd_mode` and `pin_hiz` are all low.
- R2: Five consecutive rising edges with `mode_sel` high bring the controller to its reset state from any state. This also reloads IDCODE as the active instruction.
- R3: In the data pause state the shift contents are held and `scan_out_en` is low. Resuming the shift continues the stream from the next bit.
- R4: Capture-IR loads 0001 into the instruction shifter: 01 in the two low bits and zeros above. The shifter is scanned out LSB first. A newly shifted code takes effect when the controller leaves Update-IR.
- R5: IDCODE (0010) selects the identification word and scans it LSB first. The word holds version in bits 31:28, part number in bits 27:12, manufacturer in bits 11:1, and a 1 in bit 0.
- R6: BYPASS (1111) selects a one-bit stage that captures 0 in Capture-DR. Serial data therefore emerges delayed by one shift.
- R7: Any code with no assigned instruction behaves as BYPASS and leaves `bnd_mode` and `pin_hiz` low.
- R8: CLAMP (0011) selects the bypass stage and raises `bnd_mode`. It keeps `pin_hiz` low, and the boundary strobes stay low during data scans.
- R9: HIGHZ (0100) raises `pin_hiz`, keeps `bnd_mode` low, and selects the bypass stage.
- R10: EXTEST (0000), SAMPLE/PRELOAD (0001) and INTEST (0101) route `bnd_so` to the serial output. Under these codes `bnd_capture`, `bnd_shift` and `bnd_update` are high in Capture-DR, Shift-DR and Update-DR respectively. `bnd_mode` is high for EXTEST and INTEST and low for SAMPLE/PRELOAD.
- R11: `scan_out` and `scan_out_en` change only on the falling edge of `test_clk`, and `scan_out_en` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| test_clk | input | 1 | Test clock; inputs sampled on rising edge, output launched on falling edge |
| tap_rst | input | 1 | Asynchronous active-high controller reset |
| mode_sel | input | 1 | Controller steering input |
| scan_in | input | 1 | Serial data and instruction input |
| scan_out | output | 1 | Serial output of the selected register |
| scan_out_en | output | 1 | Serial output enable |
| bnd_so | input | 1 | Serial output of the external boundary register |
| bnd_capture | output | 1 | Boundary register capture enable |
| bnd_shift | output | 1 | Boundary register shift enable |
| bnd_update | output | 1 | Boundary register update enable |
| bnd_mode | output | 1 | Pins driven from the boundary update stage |
| pin_hiz | output | 1 | Force all output pads to high impedance |

## Verification
The assertions assume that `mode_sel` and `scan_in` are stable around each rising edge of `test_clk`. They also assume that `bnd_so` is steady whenever a falling edge can launch it. The stimulus meets this by changing every input only just after a falling edge, which leaves half a period before the next rising edge, and by changing `bnd_so` only between scans. Reset is raised for several whole clock periods and released just after a falling edge, so that no register starts from an undefined value.

// File: rtl/tap_pkg.sv
package tap_pkg;

    localparam int IR_W = 4;
    localparam int ID_W = 32;

    typedef enum logic [3:0] {
        ST_RESET,
        ST_IDLE,
        ST_SEL_DR,
        ST_CAP_DR,
        ST_SH_DR,
        ST_EX1_DR,
        ST_PAUSE_DR,
        ST_EX2_DR,
        ST_UPD_DR,
        ST_SEL_IR,
        ST_CAP_IR,
        ST_SH_IR,
        ST_EX1_IR,
        ST_PAUSE_IR,
        ST_EX2_IR,
        ST_UPD_IR
    } tap_state_e;

    localparam logic [IR_W-1:0] OP_EXTEST = 4'b0000;
    localparam logic [IR_W-1:0] OP_SAMPLE = 4'b0001;
    localparam logic [IR_W-1:0] OP_IDCODE = 4'b0010;
    localparam logic [IR_W-1:0] OP_CLAMP  = 4'b0011;
    localparam logic [IR_W-1:0] OP_HIGHZ  = 4'b0100;
    localparam logic [IR_W-1:0] OP_INTEST = 4'b0101;
    localparam logic [IR_W-1:0] OP_BYPASS = 4'b1111;

    typedef enum logic [1:0] {
        PATH_BYP,
        PATH_ID,
        PATH_BND
    } dr_path_e;

    typedef struct packed {
        dr_path_e path;
        logic     bnd_drive;
        logic     hiz;
    } op_ctrl_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        case (s)
            ST_RESET:    return tms ? ST_RESET   : ST_IDLE;
            ST_IDLE:     return tms ? ST_SEL_DR  : ST_IDLE;
            ST_SEL_DR:   return tms ? ST_SEL_IR  : ST_CAP_DR;
            ST_CAP_DR:   return tms ? ST_EX1_DR  : ST_SH_DR;
            ST_SH_DR:    return tms ? ST_EX1_DR  : ST_SH_DR;
            ST_EX1_DR:   return tms ? ST_UPD_DR  : ST_PAUSE_DR;
            ST_PAUSE_DR: return tms ? ST_EX2_DR  : ST_PAUSE_DR;
            ST_EX2_DR:   return tms ? ST_UPD_DR  : ST_SH_DR;
            ST_UPD_DR:   return tms ? ST_SEL_DR  : ST_IDLE;
            ST_SEL_IR:   return tms ? ST_RESET   : ST_CAP_IR;
            ST_CAP_IR:   return tms ? ST_EX1_IR  : ST_SH_IR;
            ST_SH_IR:    return tms ? ST_EX1_IR  : ST_SH_IR;
            ST_EX1_IR:   return tms ? ST_UPD_IR  : ST_PAUSE_IR;
            ST_PAUSE_IR: return tms ? ST_EX2_IR  : ST_PAUSE_IR;
            ST_EX2_IR:   return tms ? ST_UPD_IR  : ST_SH_IR;
            default:     return tms ? ST_SEL_DR  : ST_IDLE;
        endcase
    endfunction

    function automatic op_ctrl_t op_decode(logic [IR_W-1:0] op);
        op_ctrl_t c;
        c = '{path: PATH_BYP, bnd_drive: 1'b0, hiz: 1'b0};
        case (op)
            OP_EXTEST: c = '{path: PATH_BND, bnd_drive: 1'b1, hiz: 1'b0};
            OP_SAMPLE: c = '{path: PATH_BND, bnd_drive: 1'b0, hiz: 1'b0};
            OP_IDCODE: c = '{path: PATH_ID,  bnd_drive: 1'b0, hiz: 1'b0};
            OP_CLAMP:  c = '{path: PATH_BYP, bnd_drive: 1'b1, hiz: 1'b0};
            OP_HIGHZ:  c = '{path: PATH_BYP, bnd_drive: 1'b0, hiz: 1'b1};
            OP_INTEST: c = '{path: PATH_BND, bnd_drive: 1'b1, hiz: 1'b0};
            default:   c = '{path: PATH_BYP, bnd_drive: 1'b0, hiz: 1'b0};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) state <= ST_RESET;
        else     state <= tap_next(state, tms);
    end

    // run of consecutive high steering samples, saturating at five
    logic [2:0] ones_q;
    always_ff @(posedge clk or posedge rst) begin
        if (rst)                ones_q <= 3'd0;
        else if (!tms)          ones_q <= 3'd0;
        else if (ones_q != 3'd5) ones_q <= ones_q + 3'd1;
    end

    // R2
    five_ones_reset_chk: assert property (@(posedge clk) disable iff (rst)
        (ones_q == 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            din,
    input  tap_state_e      state,
    output logic [IR_W-1:0] op,
    output logic            ir_lsb
);

    localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-2){1'b0}}, 2'b01};

    logic [IR_W-1:0] sh_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            sh_q <= '0;
            op   <= OP_IDCODE;
        end else begin
            case (state)
                ST_CAP_IR: sh_q <= CAP_PAT;
                ST_SH_IR:  sh_q <= {din, sh_q[IR_W-1:1]};
                default:   ;
            endcase
            if (state == ST_RESET)       op <= OP_IDCODE;
            else if (state == ST_UPD_IR) op <= sh_q;
        end
    end

    assign ir_lsb = sh_q[0];

    // R4
    ir_capture_pattern_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CAP_IR) |=> (sh_q[1:0] == 2'b01));

    // R1
    ir_reset_load_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_RESET) |=> (op == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter logic [ID_W-1:0] ID_VALUE = 32'h0000_0001
)(
    input  logic       clk,
    input  logic       rst,
    input  logic       din,
    input  tap_state_e state,
    input  dr_path_e   path,
    input  logic       bnd_so,
    output logic       dr_lsb
);

    logic            byp_q;
    logic [ID_W-1:0] id_q;
    logic            cap, sh;

    assign cap = (state == ST_CAP_DR);
    assign sh  = (state == ST_SH_DR);

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
        end else begin
            if (path == PATH_BYP) begin
                if (cap)     byp_q <= 1'b0;
                else if (sh) byp_q <= din;
            end
            if (path == PATH_ID) begin
                if (cap)     id_q <= ID_VALUE;
                else if (sh) id_q <= {din, id_q[ID_W-1:1]};
            end
        end
    end

    always_comb begin
        case (path)
            PATH_ID:  dr_lsb = id_q[0];
            PATH_BND: dr_lsb = bnd_so;
            default:  dr_lsb = byp_q;
        endcase
    end

    // R6
    bypass_capture_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && path == PATH_BYP) |=> (byp_q == 1'b0));

    // R5
    id_marker_bit_chk: assert property (@(posedge clk) disable iff (rst)
        (cap && path == PATH_ID) |=> (id_q[0] == 1'b1));

endmodule

// File: rtl/tap_top.sv
module tap_top
    import tap_pkg::*;
#(
    parameter logic [3:0]  ID_VERSION = 4'h3,
    parameter logic [15:0] ID_PART    = 16'hA5C1,
    parameter logic [10:0] ID_MFR     = 11'h2B7
)(
    input  logic test_clk,
    input  logic tap_rst,
    input  logic mode_sel,
    input  logic scan_in,
    output logic scan_out,
    output logic scan_out_en,
    input  logic bnd_so,
    output logic bnd_capture,
    output logic bnd_shift,
    output logic bnd_update,
    output logic bnd_mode,
    output logic pin_hiz
);

    localparam logic [ID_W-1:0] ID_VALUE = {ID_VERSION, ID_PART, ID_MFR, 1'b1};

    tap_state_e      state;
    logic [IR_W-1:0] op;
    logic            ir_lsb;
    logic            dr_lsb;
    op_ctrl_t        ctl;
    logic            bnd_sel;

    tap_fsm u_fsm (
        .clk   (test_clk),
        .rst   (tap_rst),
        .tms   (mode_sel),
        .state (state)
    );

    tap_ir u_ir (
        .clk    (test_clk),
        .rst    (tap_rst),
        .din    (scan_in),
        .state  (state),
        .op     (op),
        .ir_lsb (ir_lsb)
    );

    assign ctl     = op_decode(op);
    assign bnd_sel = (ctl.path == PATH_BND);

    tap_dr #(.ID_VALUE(ID_VALUE)) u_dr (
        .clk    (test_clk),
        .rst    (tap_rst),
        .din    (scan_in),
        .state  (state),
        .path   (ctl.path),
        .bnd_so (bnd_so),
        .dr_lsb (dr_lsb)
    );

    assign bnd_capture = bnd_sel && (state == ST_CAP_DR);
    assign bnd_shift   = bnd_sel && (state == ST_SH_DR);
    assign bnd_update  = bnd_sel && (state == ST_UPD_DR);
    assign bnd_mode    = ctl.bnd_drive;
    assign pin_hiz     = ctl.hiz;

    // serial output launched on the falling edge
    always_ff @(negedge test_clk or posedge tap_rst) begin
        if (tap_rst) begin
            scan_out    <= 1'b0;
            scan_out_en <= 1'b0;
        end else begin
            scan_out_en <= (state == ST_SH_IR) || (state == ST_SH_DR);
            if (state == ST_SH_IR)      scan_out <= ir_lsb;
            else if (state == ST_SH_DR) scan_out <= dr_lsb;
        end
    end

    // R11
    out_enable_shift_only_chk: assert property (@(posedge test_clk) disable iff (tap_rst)
        scan_out_en |-> (state == ST_SH_IR || state == ST_SH_DR));

endmodule

// File: tb/tap_top_bench.sv
module tap_top_bench;

    localparam int CLK_PERIOD = 10;
    localparam logic [3:0]  VER  = 4'h3;
    localparam logic [15:0] PART = 16'hA5C1;
    localparam logic [10:0] MFR  = 11'h2B7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic bso = 1'b0;
    logic so, so_en, b_cap, b_sh, b_upd, b_mode, hiz;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic  exp_q[$];
    string tag_q[$];

    logic [31:0] id_exp;

    always #(CLK_PERIOD/2) clk = ~clk;

    tap_top #(.ID_VERSION(VER), .ID_PART(PART), .ID_MFR(MFR)) u_tap_top (
        .test_clk    (clk),
        .tap_rst     (rst),
        .mode_sel    (tms),
        .scan_in     (tdi),
        .scan_out    (so),
        .scan_out_en (so_en),
        .bnd_so      (bso),
        .bnd_capture (b_cap),
        .bnd_shift   (b_sh),
        .bnd_update  (b_upd),
        .bnd_mode    (b_mode),
        .pin_hiz     (hiz)
    );

    task automatic check(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic step(input logic m, input logic d);
        tms = m;
        tdi = d;
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic push(input int n, input logic [31:0] bits, input string tag);
        for (int i = 0; i < n; i++) begin
            exp_q.push_back(bits[i]);
            tag_q.push_back(tag);
        end
    endtask

    // from Idle: load an instruction, checking the capture pattern
    task automatic load_ir(input logic [3:0] code);
        push(4, 32'b0001, "R4");
        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 4; i++) step(i == 3, code[i]);
        step(1, 0);
        step(0, 0);
    endtask

    // from Idle: data scan with boundary strobe expectation
    task automatic scan_dr(input int n, input logic [31:0] din, input logic [31:0] dout,
                           input logic bnd, input string tag);
        push(n, dout, tag);
        step(1, 0);
        step(0, 0);
        check({tag, " capture strobe"}, b_cap, bnd);
        step(0, 0);
        check({tag, " shift strobe"}, b_sh, bnd);
        for (int i = 0; i < n; i++) step(i == n - 1, din[i]);
        step(1, 0);
        check({tag, " update strobe"}, b_upd, bnd);
        step(0, 0);
    endtask

    // scoreboard monitor: pops one expected bit per enabled shift cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (so_en) begin
                if (exp_q.size() == 0) begin
                    check("R11 unexpected enable", so_en, 1'b0);
                end else begin
                    logic  e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(t, so, e);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        id_exp = {VER, PART, MFR, 1'b1};
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        check("R1 enable", so_en, 1'b0);
        check("R1 mode", b_mode, 1'b0);
        check("R1 hiz", hiz, 1'b0);
        step(0, 0);
        // R1 + R5: identification selected after reset
        scan_dr(32, 32'h0, id_exp, 1'b0, "R5");

        // R6 bypass one-bit delay, captured 0
        load_ir(4'b1111);
        scan_dr(5, 32'b01101, 32'b11010, 1'b0, "R6");

        // R7 unused code
        load_ir(4'b1010);
        check("R7 mode", b_mode, 1'b0);
        check("R7 hiz", hiz, 1'b0);
        scan_dr(4, 32'b1001, 32'b0010, 1'b0, "R7");

        // R8 clamp
        load_ir(4'b0011);
        check("R8 mode", b_mode, 1'b1);
        check("R8 hiz", hiz, 1'b0);
        scan_dr(3, 32'b011, 32'b110, 1'b0, "R8");

        // R9 highz
        load_ir(4'b0100);
        check("R9 hiz", hiz, 1'b1);
        check("R9 mode", b_mode, 1'b0);
        scan_dr(3, 32'b101, 32'b010, 1'b0, "R9");

        // R10 boundary instructions
        load_ir(4'b0000);
        check("R10 extest mode", b_mode, 1'b1);
        bso = 1'b1;
        scan_dr(3, 32'b000, 32'b111, 1'b1, "R10");
        load_ir(4'b0001);
        check("R10 sample mode", b_mode, 1'b0);
        bso = 1'b0;
        scan_dr(2, 32'b11, 32'b00, 1'b1, "R10");
        load_ir(4'b0101);
        check("R10 intest mode", b_mode, 1'b1);
        bso = 1'b1;
        scan_dr(2, 32'b00, 32'b11, 1'b1, "R10");
        bso = 1'b0;

        // R11 output enable changes on the falling edge
        load_ir(4'b1111);
        push(1, 32'b0, "R11");
        step(1, 0);
        step(0, 0);
        tms = 1'b0;
        @(posedge clk);
        #1;
        check("R11 before falling edge", so_en, 1'b0);
        @(negedge clk);
        #1;
        check("R11 after falling edge", so_en, 1'b1);
        step(1, 1);
        check("R11 exit shift", so_en, 1'b0);
        step(1, 0);
        step(0, 0);

        // R2 five high steering samples from Shift-DR
        push(1, 32'b0, "R2");
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 5; i++) step(1, 0);
        check("R2 enable", so_en, 1'b0);
        step(0, 0);
        scan_dr(32, 32'h0, id_exp, 1'b0, "R2");

        // R3 pause in the middle of an identification read
        push(32, id_exp, "R3");
        step(1, 0); step(0, 0); step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 0);
        step(0, 0);
        check("R3 pause enable", so_en, 1'b0);
        step(0, 0);
        step(1, 0);
        step(0, 0);
        for (int i = 0; i < 16; i++) step(i == 15, 0);
        step(1, 0);
        step(0, 0);

        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size() == 0, 1'b1);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule